// File: doc/BRIEF.md
# LCD Frame-Count Interrupt Timer with Frame-Aligned Contrast

This block turns the LCD controller's frame-start pulses into a periodic time base. A programmable reload value sets how many frames make up one period. A divide-by-eight prescaler can be kept in the path or bypassed. At the end of each period a sticky rollover flag is set, and it can drive an interrupt line. When the low-power waveform is in use, two frame-start pulses make one frame, so the period is measured in frames of double length.

Software works the block through single-cycle write strobes. Each strobe acts only when it is written as one:

- one strobe enables the interrupt mask;
- one strobe disables it;
- one strobe clears the status flag.

The block also holds a signed fine-contrast value. A new value written by software waits in a pending register. It reaches the output only at the next frame boundary, so the drive voltage never changes in the middle of a frame.

Top module: `lcd_frame_tick_timer`

## Requirements
- R1: Out of reset, `flag_o`, `mask_o` and `irq_o` are 0 and `contrast_o` is 0.
- R2: With `bypass_i`=1, `flag_o` sets on the (`reload_i`+1)-th frame after a count restart. It sets again every `reload_i`+1 frames after that.
- R3: With `bypass_i`=0, `flag_o` sets on the (`reload_i`×8+1)-th frame after a count restart. With `reload_i`=0 this is every frame.
- R4: With `lowpwr_i`=1, a frame is two `frame_start_i` pulses. The first pulse after `lowpwr_i` rises does not end a frame; the second pulse does.
- R5: If `reload_i` or `bypass_i` differs from the values held for the running count, the next frame restarts the count at zero and does not set the flag. The first frame after reset is such a restart, because the held values reset to zero.
- R6: A one on `irq_en_set_i` sets `mask_o` and a one on `irq_en_clr_i` clears it. When both are one in the same cycle, the clear wins.
- R7: `irq_o` is 1 exactly when `flag_o` and `mask_o` are both 1. `flag_o` stays set until a one is written on `stat_clr_i`.
- R8: A rollover and a status clear in the same cycle leave `flag_o` set.
- R9: `contrast_o` (two's complement, `CST_W` bits) changes only at a frame boundary. It takes the most recently written value, including a value written in the boundary cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-cycle pulse at each LCD frame start |
| lowpwr_i | input | 1 | Low-power waveform mode: two pulses per frame |
| reload_i | input | FC_W | Frame-count reload value |
| bypass_i | input | 1 | 1: divide-by-8 prescaler bypassed |
| irq_en_set_i | input | 1 | Write-one strobe that sets the interrupt mask |
| irq_en_clr_i | input | 1 | Write-one strobe that clears the interrupt mask |
| stat_clr_i | input | 1 | Write-one strobe that clears the rollover flag |
| contrast_wr_i | input | 1 | Write strobe for the pending contrast value |
| contrast_din_i | input | CST_W | Signed contrast value to be written |
| flag_o | output | 1 | Sticky rollover status |
| mask_o | output | 1 | Interrupt mask state |
| irq_o | output | 1 | Interrupt request |
| contrast_o | output | CST_W | Contrast value applied to the current frame (signed) |

## Verification
The period is checked in four settings, each of which separates a different cause:

- bypassed with a reload of 3, and prescaled with a reload of 2 (17 frames), which tells a ×8 period from a +1 period;
- prescaled with a reload of 0, which catches an off-by-one at the smallest period;
- low-power mode with a reload of 1, which shows whether pulses are halved and on which pulse the frame ends.

A reload change in the middle of a count shows whether the restart frame is wrongly counted as a rollover. Colliding strobes (enable with disable, rollover with clear) expose the wrong priority. Contrast writes made between boundaries, at a boundary, at the extreme negative value and during low-power mode show whether the latch opens on the wrong pulse.

// File: rtl/lcdft_pkg.sv
package lcdft_pkg;
   localparam int FC_W_DEF      = 5;
   localparam int CST_W_DEF     = 6;
   localparam int PRE_SHIFT_DEF = 3;

   // Terminal count (period - 1) for a given reload and prescaler choice.
   function automatic logic [31:0] term_of(input logic [31:0] reload,
                                           input logic bypass,
                                           input int shift);
      return bypass ? reload : (reload << shift);
   endfunction
endpackage

// File: rtl/lcdft_frame_gate.sv
module lcdft_frame_gate #(
   parameter bit LOWPWR_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start_i,
   input  logic lowpwr_i,
   output logic tick_o
);
   generate
      if (LOWPWR_EN) begin : g_halve
         logic phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= 1'b0;
            else if (!lowpwr_i)
               phase_q <= 1'b0;
            else if (frame_start_i)
               phase_q <= ~phase_q;
         end
         assign tick_o = frame_start_i & (~lowpwr_i | phase_q);
      end else begin : g_pass
         logic unused_lp;
         logic unused_clk;
         assign unused_lp  = lowpwr_i;
         assign unused_clk = clk ^ rst_n;
         assign tick_o     = frame_start_i;
      end
   endgenerate
endmodule

// File: rtl/lcdft_period_counter.sv
module lcdft_period_counter #(
   parameter int FC_W      = lcdft_pkg::FC_W_DEF,
   parameter int PRE_SHIFT = lcdft_pkg::PRE_SHIFT_DEF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic [FC_W-1:0] reload_i,
   input  logic            bypass_i,
   output logic            roll_o
);
   localparam int CNT_W = FC_W + PRE_SHIFT;

   logic [CNT_W-1:0] cnt_q;
   logic [FC_W-1:0]  held_reload_q;
   logic             held_bypass_q;
   logic [CNT_W-1:0] term;
   logic             restart;

   assign term    = CNT_W'(lcdft_pkg::term_of(32'(held_reload_q), held_bypass_q, PRE_SHIFT));
   assign restart = tick_i & ((reload_i != held_reload_q) | (bypass_i != held_bypass_q));
   assign roll_o  = tick_i & ~restart & (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q         <= '0;
         held_reload_q <= '0;
         held_bypass_q <= 1'b0;
      end else if (restart) begin
         cnt_q         <= '0;
         held_reload_q <= reload_i;
         held_bypass_q <= bypass_i;
      end else if (tick_i) begin
         cnt_q <= roll_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lcdft_irq_ctrl.sv
module lcdft_irq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic roll_i,
   input  logic en_set_i,
   input  logic en_clr_i,
   input  logic stat_clr_i,
   output logic flag_o,
   output logic mask_o,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         mask_o <= 1'b0;
      end else begin
         if (roll_i)          flag_o <= 1'b1;
         else if (stat_clr_i) flag_o <= 1'b0;
         if (en_clr_i)        mask_o <= 1'b0;
         else if (en_set_i)   mask_o <= 1'b1;
      end
   end
   assign irq_o = flag_o & mask_o;
endmodule

// File: rtl/lcdft_contrast_latch.sv
module lcdft_contrast_latch #(
   parameter int CST_W = lcdft_pkg::CST_W_DEF
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_i,
   input  logic                    wr_i,
   input  logic signed [CST_W-1:0] din_i,
   output logic signed [CST_W-1:0] value_o
);
   logic signed [CST_W-1:0] pend_q;
   logic signed [CST_W-1:0] pend_nxt;

   assign pend_nxt = wr_i ? din_i : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         value_o <= '0;
      end else begin
         pend_q <= pend_nxt;
         if (tick_i) value_o <= pend_nxt;
      end
   end
endmodule

// File: rtl/lcd_frame_tick_timer.sv
module lcd_frame_tick_timer #(
   parameter int FC_W      = lcdft_pkg::FC_W_DEF,
   parameter int CST_W     = lcdft_pkg::CST_W_DEF,
   parameter int PRE_SHIFT = lcdft_pkg::PRE_SHIFT_DEF,
   parameter bit LOWPWR_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_start_i,
   input  logic                    lowpwr_i,
   input  logic [FC_W-1:0]         reload_i,
   input  logic                    bypass_i,
   input  logic                    irq_en_set_i,
   input  logic                    irq_en_clr_i,
   input  logic                    stat_clr_i,
   input  logic                    contrast_wr_i,
   input  logic signed [CST_W-1:0] contrast_din_i,
   output logic                    flag_o,
   output logic                    mask_o,
   output logic                    irq_o,
   output logic signed [CST_W-1:0] contrast_o
);
   generate
      if (FC_W < 1 || FC_W + PRE_SHIFT > 31) begin : g_bad_fc
         $error("lcd_frame_tick_timer: FC_W + PRE_SHIFT must lie in 1..31");
      end
      if (CST_W < 2) begin : g_bad_cst
         $error("lcd_frame_tick_timer: CST_W must be at least 2 for a signed value");
      end
   endgenerate

   logic tick;
   logic roll;

   lcdft_frame_gate #(.LOWPWR_EN(LOWPWR_EN)) u_gate (
      .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
      .lowpwr_i(lowpwr_i), .tick_o(tick));

   lcdft_period_counter #(.FC_W(FC_W), .PRE_SHIFT(PRE_SHIFT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .reload_i(reload_i),
      .bypass_i(bypass_i), .roll_o(roll));

   lcdft_irq_ctrl u_irq (
      .clk(clk), .rst_n(rst_n), .roll_i(roll), .en_set_i(irq_en_set_i),
      .en_clr_i(irq_en_clr_i), .stat_clr_i(stat_clr_i),
      .flag_o(flag_o), .mask_o(mask_o), .irq_o(irq_o));

   lcdft_contrast_latch #(.CST_W(CST_W)) u_cst (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_i(contrast_wr_i),
      .din_i(contrast_din_i), .value_o(contrast_o));
endmodule

// File: rtl/lcdft_checker.sv
module lcdft_checker #(
   parameter int CST_W = 6
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    frame_start_i,
   input logic                    irq_en_set_i,
   input logic                    irq_en_clr_i,
   input logic                    stat_clr_i,
   input logic                    flag_o,
   input logic                    mask_o,
   input logic signed [CST_W-1:0] contrast_o
);
   a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en_set_i && !irq_en_clr_i |=> mask_o);
   a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en_clr_i |=> !mask_o);
   a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_set_i && !irq_en_clr_i |=> $stable(mask_o));
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o && !stat_clr_i |=> flag_o);
   a_r7_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr_i && !frame_start_i |=> !flag_o);
   a_r2_flag_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_o && !frame_start_i |=> !flag_o);
   a_r9_contrast_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start_i |=> $stable(contrast_o));
endmodule

bind lcd_frame_tick_timer lcdft_checker #(.CST_W(CST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
   .irq_en_set_i(irq_en_set_i), .irq_en_clr_i(irq_en_clr_i),
   .stat_clr_i(stat_clr_i), .flag_o(flag_o), .mask_o(mask_o),
   .contrast_o(contrast_o));

// File: tb/tb_lcd_frame_tick_timer.sv
module tb_lcd_frame_tick_timer;
   localparam int FC_W  = 5;
   localparam int CST_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start_i = 1'b0, lowpwr_i = 1'b0, bypass_i = 1'b0;
   logic [FC_W-1:0] reload_i = '0;
   logic irq_en_set_i = 1'b0, irq_en_clr_i = 1'b0, stat_clr_i = 1'b0;
   logic contrast_wr_i = 1'b0;
   logic signed [CST_W-1:0] contrast_din_i = '0;
   logic flag_o, mask_o, irq_o;
   logic signed [CST_W-1:0] contrast_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lcd_frame_tick_timer #(.FC_W(FC_W), .CST_W(CST_W)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
      .lowpwr_i(lowpwr_i), .reload_i(reload_i), .bypass_i(bypass_i),
      .irq_en_set_i(irq_en_set_i), .irq_en_clr_i(irq_en_clr_i),
      .stat_clr_i(stat_clr_i), .contrast_wr_i(contrast_wr_i),
      .contrast_din_i(contrast_din_i), .flag_o(flag_o), .mask_o(mask_o),
      .irq_o(irq_o), .contrast_o(contrast_o));

   task automatic chk(input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) frame_start_i = 1'b1;
         @(negedge clk) frame_start_i = 1'b0;
      end
   endtask

   task automatic clear_flag();
      @(negedge clk) stat_clr_i = 1'b1;
      @(negedge clk) stat_clr_i = 1'b0;
   endtask

   task automatic t_reset();
      chk(flag_o, 0, "R1 flag after reset");
      chk(mask_o, 0, "R1 mask after reset");
      chk(irq_o, 0, "R1 irq after reset");
      chk(contrast_o, 0, "R1 contrast after reset");
   endtask

   task automatic t_bypass();
      bypass_i = 1'b1; reload_i = 5'd3;
      pulses(1);
      chk(flag_o, 0, "R5 restart frame sets no flag");
      pulses(3);
      chk(flag_o, 0, "R2 flag clear before frame 4");
      pulses(1);
      chk(flag_o, 1, "R2 flag on frame reload+1");
      clear_flag();
      chk(flag_o, 0, "R7 status clear");
      pulses(3);
      chk(flag_o, 0, "R2 second period not yet over");
      pulses(1);
      chk(flag_o, 1, "R2 second period");
      clear_flag();
   endtask

   task automatic t_restart_mid();
      pulses(2);
      reload_i = 5'd1;
      pulses(1);
      chk(flag_o, 0, "R5 mid-count change restarts");
      pulses(1);
      chk(flag_o, 0, "R5 one frame after restart");
      pulses(1);
      chk(flag_o, 1, "R5 new period after restart");
      clear_flag();
   endtask

   task automatic t_prescaled();
      bypass_i = 1'b0; reload_i = 5'd2;
      pulses(1);
      chk(flag_o, 0, "R5 restart on bypass change");
      pulses(16);
      chk(flag_o, 0, "R3 flag clear after 16 frames");
      pulses(1);
      chk(flag_o, 1, "R3 flag on frame 17");
      clear_flag();
      reload_i = 5'd0;
      pulses(1);
      chk(flag_o, 0, "R5 restart on reload 0");
      pulses(1);
      chk(flag_o, 1, "R3 reload 0 rolls each frame");
      clear_flag();
   endtask

   task automatic t_lowpwr();
      lowpwr_i = 1'b1; bypass_i = 1'b1; reload_i = 5'd1;
      @(negedge clk) begin contrast_wr_i = 1'b1; contrast_din_i = 6'sd7; end
      @(negedge clk) contrast_wr_i = 1'b0;
      pulses(1);
      chk(contrast_o, 0, "R4 first low-power pulse ends no frame");
      pulses(1);
      chk(contrast_o, 7, "R4 second pulse ends frame");
      chk(flag_o, 0, "R5 low-power restart frame");
      pulses(3);
      chk(flag_o, 0, "R4 flag clear after 5 pulses");
      pulses(1);
      chk(flag_o, 1, "R4 flag after 2 double frames");
      clear_flag();
      lowpwr_i = 1'b0;
   endtask

   task automatic t_mask();
      bypass_i = 1'b1; reload_i = 5'd0;
      pulses(2);
      chk(flag_o, 1, "R7 flag set for mask test");
      chk(irq_o, 0, "R7 masked flag gives no irq");
      @(negedge clk) irq_en_set_i = 1'b1;
      @(negedge clk) irq_en_set_i = 1'b0;
      chk(mask_o, 1, "R6 enable strobe");
      chk(irq_o, 1, "R7 irq with flag and mask");
      @(negedge clk) irq_en_clr_i = 1'b1;
      @(negedge clk) irq_en_clr_i = 1'b0;
      chk(irq_o, 0, "R6 disable strobe drops irq");
      chk(flag_o, 1, "R7 flag kept after disable");
      @(negedge clk) begin irq_en_set_i = 1'b1; irq_en_clr_i = 1'b1; end
      @(negedge clk) begin irq_en_set_i = 1'b0; irq_en_clr_i = 1'b0; end
      chk(mask_o, 0, "R6 clear wins over set");
      @(negedge clk) irq_en_set_i = 1'b1;
      @(negedge clk) irq_en_set_i = 1'b0;
      clear_flag();
      chk(irq_o, 0, "R7 irq drops on status clear");
   endtask

   task automatic t_setwins();
      pulses(1);
      chk(flag_o, 1, "R8 flag set before collision");
      @(negedge clk) begin frame_start_i = 1'b1; stat_clr_i = 1'b1; end
      @(negedge clk) begin frame_start_i = 1'b0; stat_clr_i = 1'b0; end
      chk(flag_o, 1, "R8 rollover beats clear");
      clear_flag();
      chk(flag_o, 0, "R8 later clear works");
   endtask

   task automatic t_contrast();
      @(negedge clk) begin contrast_wr_i = 1'b1; contrast_din_i = -6'sd5; end
      @(negedge clk) contrast_wr_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(contrast_o, 7, "R9 write between frames not applied");
      pulses(1);
      chk(contrast_o, -5, "R9 applied at frame");
      @(negedge clk) begin contrast_wr_i = 1'b1; contrast_din_i = 6'sd31; frame_start_i = 1'b1; end
      @(negedge clk) begin contrast_wr_i = 1'b0; frame_start_i = 1'b0; end
      chk(contrast_o, 31, "R9 write in boundary cycle");
      @(negedge clk) begin contrast_wr_i = 1'b1; contrast_din_i = -6'sd32; end
      @(negedge clk) contrast_wr_i = 1'b0;
      pulses(1);
      chk(contrast_o, -32, "R9 most negative value");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bypass();
      t_restart_mid();
      t_prescaled();
      t_lowpwr();
      t_mask();
      t_setwins();
      t_contrast();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule